// File: doc/BRIEF.md
# Flash Timer and LED Mode Controller

This block sits between a camera-flash driver's register bank and its analog power stage. It turns the stored command byte into one of four operating modes (off, idle, torch, flash) and drives the enables for the main flash path, the torch path and a small auxiliary indicator LED. It also tells the power stage which dimming field applies and when the temperature sensor must be powered.

Flash light is metered by a step timer. Each step is `TICK_DIV` clock cycles, which is 100 ms in silicon and a few cycles in simulation. The timer advances only while the trigger pin is high and holds its count while the pin is low, so several short pulses share one budget. When the budget runs out the block emits a one-cycle timeout event and asks the register bank to clear the flash-arm bit. Rewriting the command byte reloads the budget, which lets software stretch a flash past the 15-step ceiling.

The auxiliary LED has a second, identical step timer. It runs only in idle mode, and its current code is passed through while it is lit. All outputs are registered, so every input takes effect on the output one clock edge later. The block has no data stream: every pin is a plain control or status level, and there is no back-pressure.

Top module: `flash_mode_ctrl`

## Requirements
- R1: The command byte is decoded as bit 7 power, bit 6 flash-arm, bit 5 torch request, bit 4 sensor request, bits 3:0 step count. `mode_o` reads 0 when power is 0. It reads 1 (idle) when power is 1 and both arm and torch are 0, 2 (torch) when power is 1, arm is 0 and torch is 1, and 3 (flash) when power and arm are both 1, whatever the torch bit holds. `mode_o` shows this one edge after the byte is presented.
- R2: `flash_led_en` is high only in flash mode, only while the trigger has been high at the preceding edge, and only while the step budget is not spent. The torch bit has no effect in flash mode: `torch_led_en` stays 0.
- R3: Each edge with flash mode, trigger high and budget left consumes one cycle of budget. A load of step count N gives exactly N×`TICK_DIV` lit cycles in total. The count pauses while the trigger is low, so split pulses add up to the same total.
- R4: The edge that spends the last cycle of budget raises `timeout_evt` and `trig_en_clr` for one cycle. Loading a step count of 0 raises them on the next cycle and lights nothing.
- R5: A command write (`cmd_wr` high) in flash mode reloads the full budget and restarts the step phase. The write cycle itself is unlit. If the write lands on the edge that would have spent the budget, no timeout is raised for it.
- R6: Torch mode has no timer. `torch_led_en` stays high until a different command byte is written, and no timeout is ever raised in torch mode.
- R7: `ntc_en` is high when the sensor bit is set, and also in torch or flash mode whatever the sensor bit holds.
- R8: While `force_ready` is high with power set, the next cycle shows mode 1 with flash and torch enables low. The flash budget is discarded, so the light does not return once `force_ready` falls, until the next command write.
- R9: The auxiliary LED lights only in idle mode, for (aux byte bits 3:0)×`TICK_DIV` cycles after an `aux_wr`. `aux_cur` shows aux byte bits 7:4 while it is lit and 0 otherwise. An `aux_wr` outside idle mode is ignored, and leaving idle mode stops the auxiliary LED at once.
- R10: `dim_flash_sel` is 1 in flash mode and 0 in every other mode.
- R11: After reset, the mode is 0 and every enable, event and selector output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_reg | input | 8 | Stored command byte from the register bank |
| cmd_wr | input | 1 | One-cycle strobe: command byte was written |
| aux_reg | input | 8 | Stored auxiliary byte: current code in 7:4, step count in 3:0 |
| aux_wr | input | 1 | One-cycle strobe: auxiliary byte was written |
| trig | input | 1 | Flash trigger pin, already synchronised |
| force_ready | input | 1 | Fault latch from the status logic, forces idle mode |
| mode_o | output | 2 | Active mode: 0 off, 1 idle, 2 torch, 3 flash |
| flash_led_en | output | 1 | Enable for the flash current path |
| torch_led_en | output | 1 | Enable for the torch current path |
| aux_led_en | output | 1 | Enable for the auxiliary LED |
| aux_cur | output | 4 | Auxiliary current code, 0 when unlit |
| dim_flash_sel | output | 1 | 1 selects the flash dimming field, 0 the torch field |
| ntc_en | output | 1 | Power for the temperature sensing divider |
| timeout_evt | output | 1 | One-cycle pulse when the flash budget runs out |
| trig_en_clr | output | 1 | One-cycle request to clear the flash-arm bit |

## Verification
The command reload and the budget expiry can fall on the same clock edge. The bench provokes this by arming a one-step flash and holding the trigger high for exactly `TICK_DIV`−1 edges, then presenting the rewrite on the edge that would spend the last cycle. The result is judged by two counts: total lit cycles must equal the pre-write cycles plus one fresh budget, and exactly one timeout must be seen, from the later expiry. A fault force landing during a live flash is checked the same way, by counting lit cycles and timeouts.

// File: rtl/fmc_pkg.sv
package fmc_pkg;
  localparam int STEP_W = 4;
  localparam int AUX_CUR_W = 4;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_IDLE  = 2'd1,
    MODE_TORCH = 2'd2,
    MODE_FLASH = 2'd3
  } fmc_mode_e;
endpackage

// File: rtl/fmc_mode_decode.sv
module fmc_mode_decode
  import fmc_pkg::*;
(
  input  logic [7:0]        cmd,
  input  logic              force_idle,
  output fmc_mode_e         mode,
  output logic              sense_req,
  output logic [STEP_W-1:0] steps
);
  logic pwr, arm, tch;

  always_comb begin
    pwr       = cmd[7];
    arm       = cmd[6];
    tch       = cmd[5];
    sense_req = cmd[4];
    steps     = cmd[STEP_W-1:0];
    if (!pwr)            mode = MODE_OFF;
    else if (force_idle) mode = MODE_IDLE;
    else if (arm)        mode = MODE_FLASH;
    else if (tch)        mode = MODE_TORCH;
    else                 mode = MODE_IDLE;
  end
endmodule

// File: rtl/fmc_step_timer.sv
module fmc_step_timer #(
  parameter int TICK_DIV = 10_000_000,
  parameter int STEP_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [STEP_W-1:0] load_val,
  input  logic              cancel,
  input  logic              run,
  output logic              busy,
  output logic              expire
);
  localparam int PRE_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  logic [PRE_W-1:0]  pre_q;
  logic [STEP_W-1:0] steps_q;
  logic              wrap;

  assign busy   = (steps_q != '0);
  assign wrap   = run && busy && (pre_q == PRE_LAST);
  assign expire = wrap && !load && !cancel && (steps_q == STEP_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      steps_q <= '0;
    end else if (load) begin
      pre_q   <= '0;
      steps_q <= load_val;
    end else if (cancel) begin
      pre_q   <= '0;
      steps_q <= '0;
    end else if (run && busy) begin
      if (wrap) begin
        pre_q   <= '0;
        steps_q <= steps_q - STEP_W'(1);
      end else begin
        pre_q   <= pre_q + PRE_W'(1);
      end
    end
  end
endmodule

// File: rtl/flash_mode_ctrl.sv
module flash_mode_ctrl
  import fmc_pkg::*;
#(
  parameter int TICK_DIV = 10_000_000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [7:0]           cmd_reg,
  input  logic                 cmd_wr,
  input  logic [7:0]           aux_reg,
  input  logic                 aux_wr,
  input  logic                 trig,
  input  logic                 force_ready,
  output logic [1:0]           mode_o,
  output logic                 flash_led_en,
  output logic                 torch_led_en,
  output logic                 aux_led_en,
  output logic [AUX_CUR_W-1:0] aux_cur,
  output logic                 dim_flash_sel,
  output logic                 ntc_en,
  output logic                 timeout_evt,
  output logic                 trig_en_clr
);
  fmc_mode_e         mode_d, mode_q;
  logic              sense_req;
  logic [STEP_W-1:0] ftim;

  fmc_mode_decode u_dec (
    .cmd        (cmd_reg),
    .force_idle (force_ready),
    .mode       (mode_d),
    .sense_req  (sense_req),
    .steps      (ftim)
  );

  logic is_flash, is_torch, is_idle;
  assign is_flash = (mode_d == MODE_FLASH);
  assign is_torch = (mode_d == MODE_TORCH);
  assign is_idle  = (mode_d == MODE_IDLE);

  // flash budget
  logic f_load, f_cancel, f_run, f_busy, f_expire, f_zero_load;
  assign f_load      = cmd_wr && is_flash;
  assign f_cancel    = (cmd_wr && !is_flash) || force_ready;
  assign f_run       = is_flash && trig;
  assign f_zero_load = f_load && (ftim == '0);

  fmc_step_timer #(.TICK_DIV(TICK_DIV), .STEP_W(STEP_W)) u_flash_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (f_load),
    .load_val (ftim),
    .cancel   (f_cancel),
    .run      (f_run),
    .busy     (f_busy),
    .expire   (f_expire)
  );

  // auxiliary budget
  logic a_load, a_cancel, a_busy, a_expire;
  assign a_load   = aux_wr && is_idle;
  assign a_cancel = !is_idle;

  fmc_step_timer #(.TICK_DIV(TICK_DIV), .STEP_W(STEP_W)) u_aux_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (a_load),
    .load_val (aux_reg[STEP_W-1:0]),
    .cancel   (a_cancel),
    .run      (is_idle),
    .busy     (a_busy),
    .expire   (a_expire)
  );

  logic flash_d, aux_d, end_d;
  assign flash_d = f_run && f_busy && !cmd_wr && !force_ready;
  assign aux_d   = is_idle && a_busy && !aux_wr;
  assign end_d   = f_expire || f_zero_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q        <= MODE_OFF;
      flash_led_en  <= 1'b0;
      torch_led_en  <= 1'b0;
      aux_led_en    <= 1'b0;
      aux_cur       <= '0;
      dim_flash_sel <= 1'b0;
      ntc_en        <= 1'b0;
      timeout_evt   <= 1'b0;
      trig_en_clr   <= 1'b0;
    end else begin
      mode_q        <= mode_d;
      flash_led_en  <= flash_d;
      torch_led_en  <= is_torch;
      aux_led_en    <= aux_d;
      aux_cur       <= aux_d ? aux_reg[7:8-AUX_CUR_W] : '0;
      dim_flash_sel <= is_flash;
      ntc_en        <= sense_req || is_torch || is_flash;
      timeout_evt   <= end_d;
      trig_en_clr   <= end_d;
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/fmc_checker.sv
module fmc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] cmd_reg,
  input logic       trig,
  input logic       force_ready,
  input logic [1:0] mode_o,
  input logic       flash_led_en,
  input logic       torch_led_en,
  input logic       aux_led_en,
  input logic [3:0] aux_cur,
  input logic       ntc_en
);
  // R2: flash light needs flash mode and a trigger seen at the previous edge
  a_r2_flash_gated: assert property (@(posedge clk) disable iff (!rst_n)
    flash_led_en |-> (mode_o == 2'd3) && $past(trig));

  // R2, R9: at most one light path at a time
  a_r2_one_path: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flash_led_en, torch_led_en, aux_led_en}));

  // R7: sensing is powered whenever torch or flash light is on
  a_r7_sense_on: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_led_en || torch_led_en) |-> ntc_en);

  // R8: a powered force drops the main light and shows idle next cycle
  a_r8_force_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (force_ready && cmd_reg[7]) |=> (mode_o == 2'd1) && !flash_led_en && !torch_led_en);

  // R9: auxiliary light only in idle mode, current code zero when dark
  a_r9_aux_idle: assert property (@(posedge clk) disable iff (!rst_n)
    aux_led_en |-> (mode_o == 2'd1));
  a_r9_aux_dark: assert property (@(posedge clk) disable iff (!rst_n)
    !aux_led_en |-> (aux_cur == 4'd0));

  // R1: power off means everything dark
  a_r1_off_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd0) |-> !flash_led_en && !torch_led_en && !aux_led_en);
endmodule

bind flash_mode_ctrl fmc_checker u_fmc_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_reg      (cmd_reg),
  .trig         (trig),
  .force_ready  (force_ready),
  .mode_o       (mode_o),
  .flash_led_en (flash_led_en),
  .torch_led_en (torch_led_en),
  .aux_led_en   (aux_led_en),
  .aux_cur      (aux_cur),
  .ntc_en       (ntc_en)
);

// File: tb/test_flash_mode_ctrl.sv
module test_flash_mode_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int TD = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cmd_reg = 8'h00;
  logic       cmd_wr = 1'b0;
  logic [7:0] aux_reg = 8'h00;
  logic       aux_wr = 1'b0;
  logic       trig = 1'b0;
  logic       force_ready = 1'b0;
  logic [1:0] mode_o;
  logic       flash_led_en, torch_led_en, aux_led_en;
  logic [3:0] aux_cur;
  logic       dim_flash_sel, ntc_en, timeout_evt, trig_en_clr;

  int checks = 0, errors = 0;
  int on_n, to_n, clr_n, aon_n, cbad_n;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_mode_ctrl #(.TICK_DIV(TD)) i_flash_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_reg(cmd_reg), .cmd_wr(cmd_wr),
    .aux_reg(aux_reg), .aux_wr(aux_wr), .trig(trig), .force_ready(force_ready),
    .mode_o(mode_o), .flash_led_en(flash_led_en), .torch_led_en(torch_led_en),
    .aux_led_en(aux_led_en), .aux_cur(aux_cur), .dim_flash_sel(dim_flash_sel),
    .ntc_en(ntc_en), .timeout_evt(timeout_evt), .trig_en_clr(trig_en_clr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_acc();
    on_n = 0; to_n = 0; clr_n = 0; aon_n = 0; cbad_n = 0;
  endtask

  // one cycle: wait for the falling edge, sample, then release strobes
  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (flash_led_en) on_n++;
      if (timeout_evt) to_n++;
      if (trig_en_clr) begin clr_n++; cmd_reg[6] = 1'b0; end
      if (aux_led_en) aon_n++;
      if (aux_led_en && aux_cur != aux_reg[7:4]) cbad_n++;
      if (!aux_led_en && aux_cur != 4'd0) cbad_n++;
      cmd_wr = 1'b0;
      aux_wr = 1'b0;
    end
  endtask

  task automatic write_cmd(input logic [7:0] v);
    cmd_reg = v; cmd_wr = 1'b1; step(1);
  endtask

  task automatic write_aux(input logic [7:0] v);
    aux_reg = v; aux_wr = 1'b1; step(1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    clear_acc();
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(mode_o == 2'd0 && !flash_led_en && !torch_led_en && !aux_led_en &&
        !ntc_en && !timeout_evt && !trig_en_clr && !dim_flash_sel,
        "R11", int'(mode_o), 0);
    rst_n = 1'b1;
    step(1);

    // R1 idle decode, R10 selector low
    write_cmd(8'h80);
    chk(mode_o == 2'd1, "R1", int'(mode_o), 1);
    chk(dim_flash_sel == 1'b0, "R10", int'(dim_flash_sel), 0);

    // R3/R4 sweep over every nonzero step count with one long pulse
    for (int f = 1; f < 16; f++) begin
      write_cmd(8'hC0 | 8'(f));
      step(2);
      if (f == 1) begin
        chk(mode_o == 2'd3, "R1", int'(mode_o), 3);
        chk(dim_flash_sel == 1'b1, "R10", int'(dim_flash_sel), 1);
        chk(ntc_en == 1'b1, "R7", int'(ntc_en), 1);
        chk(flash_led_en == 1'b0, "R2", int'(flash_led_en), 0);
      end
      clear_acc();
      trig = 1'b1;
      step(f * TD + 4);
      trig = 1'b0;
      step(2);
      chk(on_n == f * TD, "R3", on_n, f * TD);
      chk(to_n == 1, "R4", to_n, 1);
      chk(clr_n == 1, "R4", clr_n, 1);
    end

    // R2 torch bit ignored in flash mode
    write_cmd(8'hE2);
    step(1);
    chk(mode_o == 2'd3, "R1", int'(mode_o), 3);
    chk(torch_led_en == 1'b0, "R2", int'(torch_led_en), 0);
    write_cmd(8'h80);

    // R3 split pulses share one budget of 3 steps
    write_cmd(8'hC3);
    clear_acc();
    trig = 1'b1; step(5); trig = 1'b0; step(3);
    chk(on_n == 5 && to_n == 0, "R3", on_n, 5);
    for (int p = 0; p < 2; p++) begin
      trig = 1'b1; step(5); trig = 1'b0; step(3);
    end
    chk(on_n == 3 * TD, "R3", on_n, 3 * TD);
    chk(to_n == 1, "R4", to_n, 1);

    // R4 zero step count: immediate timeout, no light
    clear_acc();
    trig = 1'b1;
    write_cmd(8'hC0);
    step(3);
    trig = 1'b0;
    chk(to_n == 1, "R4", to_n, 1);
    chk(on_n == 0, "R4", on_n, 0);

    // R5 reload mid-flash extends by a full budget
    write_cmd(8'hC2);
    clear_acc();
    trig = 1'b1; step(5);
    write_cmd(8'hC2);
    step(20); trig = 1'b0; step(1);
    chk(on_n == 5 + 2 * TD, "R5", on_n, 5 + 2 * TD);
    chk(to_n == 1, "R5", to_n, 1);

    // R5 reload on the very edge of expiry
    write_cmd(8'hC1);
    clear_acc();
    trig = 1'b1; step(TD - 1);
    write_cmd(8'hC1);
    step(10); trig = 1'b0; step(1);
    chk(on_n == (TD - 1) + TD, "R5", on_n, 2 * TD - 1);
    chk(to_n == 1, "R5", to_n, 1);

    // R8 force during a live flash
    write_cmd(8'hC4);
    clear_acc();
    trig = 1'b1; step(3);
    force_ready = 1'b1; step(1);
    chk(flash_led_en == 1'b0, "R8", int'(flash_led_en), 0);
    chk(mode_o == 2'd1, "R8", int'(mode_o), 1);
    step(2); force_ready = 1'b0; step(30); trig = 1'b0;
    chk(on_n == 3, "R8", on_n, 3);
    chk(to_n == 0, "R8", to_n, 0);

    // R6/R7 torch with sensor bit clear
    clear_acc();
    write_cmd(8'hA0);
    step(50);
    chk(torch_led_en == 1'b1 && mode_o == 2'd2, "R6", int'(torch_led_en), 1);
    chk(ntc_en == 1'b1, "R7", int'(ntc_en), 1);
    chk(to_n == 0, "R6", to_n, 0);
    write_cmd(8'h80);
    chk(torch_led_en == 1'b0, "R6", int'(torch_led_en), 0);
    chk(ntc_en == 1'b0, "R7", int'(ntc_en), 0);
    write_cmd(8'h90);
    chk(ntc_en == 1'b1, "R7", int'(ntc_en), 1);

    // R9 auxiliary LED in idle mode
    write_cmd(8'h80);
    clear_acc();
    write_aux(8'h53);
    step(20);
    chk(aon_n == 3 * TD, "R9", aon_n, 3 * TD);
    chk(cbad_n == 0, "R9", cbad_n, 0);

    // R9 auxiliary write ignored in torch mode
    write_cmd(8'hA0);
    clear_acc();
    write_aux(8'h53);
    step(20);
    chk(aon_n == 0, "R9", aon_n, 0);

    // R9 leaving idle stops the auxiliary LED
    write_cmd(8'h80);
    clear_acc();
    write_aux(8'h54);
    step(3);
    write_cmd(8'hA0);
    step(20);
    chk(aon_n == 3, "R9", aon_n, 3);
    chk(cbad_n == 0, "R9", cbad_n, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule